// File: doc/BRIEF.md
# Periodic Interval Pulse Generator

This block turns a free-running nanosecond time base into periodic output pulses, for example a one-pulse-per-second marker. The time base is represented by a tick enable and a tick period: every cycle in which the tick enable is high, time advances by the tick period in nanoseconds. Up to three channels share that time base. Each channel holds its own programmed interval, counts it down by the tick period on every tick, emits a pulse when the count is used up, and then starts the next interval from the programmed value.

The programmed interval is the desired pulse spacing minus one tick period. For a 1 Hz output with a 10 ns tick, the interval is 999,999,990. The pulse width is set by a prescale value shared by all channels. It equals one period of the prescaled output clock, which is `prescale` ticks. With a 10 ns tick and a prescale of 100 this gives a 1 µs pulse. A single event flag reports every pulse start on any channel.

Channels can be enabled and disabled one at a time. A disabled channel keeps its output low and reloads its count, so the first pulse after it is enabled comes one full interval later. The interval inputs can be changed at any time. A new value is picked up only when the running interval ends.

Top module: `pulse_interval_gen`

## Requirements
- R1: While `rst_n` is low, every `pulse_out` bit and `event_flag` are 0.
- R2: A channel whose `ch_enable` bit is low at a clock edge drives its `pulse_out` bit to 0 after that edge.
- R3: For an enabled channel with interval I and tick period T, consecutive rising edges of its pulse are ceil(I/T)+1 ticks apart. When I is a multiple of T this equals I+T nanoseconds of elapsed tick time.
- R4: After a channel is enabled, its first rising edge comes on tick number ceil(I/T)+1 counted from the enable. I is the interval value present while the channel was still disabled.
- R5: Each pulse stays high for exactly P ticks, where P is the prescale value latched at the pulse start. A prescale of 0 acts as 1.
- R6: In a cycle with `tick_en` low, the pulse output of an enabled channel does not change and no event is raised.
- R7: A change to a channel's interval input does not affect the interval already running. It applies from the next pulse start, using the value present on the tick where that pulse starts.
- R8: Enabling, disabling or reprogramming one channel does not change the timing of any other channel.
- R9: `event_flag` is high for the one cycle that follows each clock edge at which any channel starts a pulse, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time base advances by `tick_period` in this cycle |
| tick_period | input | PERIOD_W | Nanoseconds per tick, must be nonzero |
| prescale | input | PRSC_W | Pulse width in ticks, shared by all channels |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_interval | input | NUM_CH*CNT_W | Per-channel interval in ns, channel i at bits [i*CNT_W +: CNT_W] |
| pulse_out | output | NUM_CH | Per-channel pulse line |
| event_flag | output | 1 | One-cycle flag for any pulse start |

## Verification
A directed run uses a 10 ns tick with one interval that is a multiple of the tick and one that is not. This separates exact spacing from rounding up of a partial last tick. Tick stalls with `tick_en` held low show that spacing counts ticks, not clock cycles. A mid-interval write to the interval input, toggling a neighbouring channel, and a prescale of 0 cover deferred reload, channel independence and the minimum pulse width. Random rounds then vary the tick period, the intervals, the prescale and the tick density together, which exposes off-by-one errors in the reload and width counters that fixed values could hide.

// File: rtl/pig_pkg.sv
package pig_pkg;

   // Largest channel count the block supports.
   localparam int unsigned PIG_MAX_CH = 3;

   // Per-channel status handed from a channel to the merging stage.
   typedef struct packed {
      logic start;   // pulse starts at this edge
      logic level;   // current pulse level
   } pig_ch_status_t;

endpackage

// File: rtl/pig_countdown.sv
module pig_countdown #(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                tick,
   input  logic [PERIOD_W-1:0] period,
   input  logic [CNT_W-1:0]    interval,
   output logic                expire
);

   localparam int unsigned PAD_W = CNT_W - PERIOD_W;

   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] step;
   logic             at_zero;

   assign step    = {{PAD_W{1'b0}}, period};
   assign at_zero = (remain_q == '0);
   assign expire  = enable & tick & at_zero;

   // Remaining time saturates at zero; the tick after reaching zero ends the interval.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (!enable) begin
         remain_q <= interval;
      end else if (tick) begin
         if (at_zero) begin
            remain_q <= interval;
         end else if (remain_q <= step) begin
            remain_q <= '0;
         end else begin
            remain_q <= remain_q - step;
         end
      end
   end

endmodule

// File: rtl/pig_stretch.sv
module pig_stretch #(
   parameter int unsigned PRSC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              start,
   input  logic [PRSC_W-1:0] prescale,
   output logic              level
);

   logic [PRSC_W-1:0] left_q;
   logic [PRSC_W-1:0] load_val;
   logic              level_q;

   // A prescale of zero is treated as a width of one tick.
   assign load_val = (prescale == '0) ? '0 : prescale - PRSC_W'(1);
   assign level    = level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         left_q  <= '0;
      end else if (!enable) begin
         level_q <= 1'b0;
         left_q  <= '0;
      end else if (start) begin
         level_q <= 1'b1;
         left_q  <= load_val;
      end else if (tick && level_q) begin
         if (left_q == '0) begin
            level_q <= 1'b0;
         end else begin
            left_q <= left_q - PRSC_W'(1);
         end
      end
   end

endmodule

// File: rtl/pig_channel.sv
module pig_channel
   import pig_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned PERIOD_W = 8,
   parameter int unsigned PRSC_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                tick,
   input  logic [PERIOD_W-1:0] period,
   input  logic [PRSC_W-1:0]   prescale,
   input  logic [CNT_W-1:0]    interval,
   output pig_ch_status_t      status
);

   logic expire;
   logic level;

   pig_countdown #(
      .CNT_W    (CNT_W),
      .PERIOD_W (PERIOD_W)
   ) u_countdown (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .tick     (tick),
      .period   (period),
      .interval (interval),
      .expire   (expire)
   );

   pig_stretch #(
      .PRSC_W (PRSC_W)
   ) u_stretch (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .tick     (tick),
      .start    (expire),
      .prescale (prescale),
      .level    (level)
   );

   assign status.start = expire;
   assign status.level = level;

endmodule

// File: rtl/pulse_interval_gen.sv
module pulse_interval_gen
   import pig_pkg::*;
#(
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned PERIOD_W = 8,
   parameter int unsigned PRSC_W   = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_en,
   input  logic [PERIOD_W-1:0]       tick_period,
   input  logic [PRSC_W-1:0]         prescale,
   input  logic [NUM_CH-1:0]         ch_enable,
   input  logic [NUM_CH*CNT_W-1:0]   ch_interval,
   output logic [NUM_CH-1:0]         pulse_out,
   output logic                      event_flag
);

   localparam int unsigned BUS_W = NUM_CH * CNT_W;

   // Elaboration-time parameter checks.
   if (NUM_CH < 1 || NUM_CH > PIG_MAX_CH) begin : g_bad_num_ch
      $error("pulse_interval_gen: NUM_CH must lie in 1..%0d", PIG_MAX_CH);
   end
   if (CNT_W <= PERIOD_W) begin : g_bad_cnt_w
      $error("pulse_interval_gen: CNT_W must exceed PERIOD_W");
   end
   if (PRSC_W < 1 || PERIOD_W < 1) begin : g_bad_small_w
      $error("pulse_interval_gen: PRSC_W and PERIOD_W must be at least 1");
   end
   if (BUS_W != NUM_CH * CNT_W) begin : g_bad_bus_w
      $error("pulse_interval_gen: interval bus width mismatch");
   end

   pig_ch_status_t       ch_status [NUM_CH];
   logic [NUM_CH-1:0]    start_vec;
   logic                 event_q;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pig_channel #(
         .CNT_W    (CNT_W),
         .PERIOD_W (PERIOD_W),
         .PRSC_W   (PRSC_W)
      ) u_channel (
         .clk      (clk),
         .rst_n    (rst_n),
         .enable   (ch_enable[g]),
         .tick     (tick_en),
         .period   (tick_period),
         .prescale (prescale),
         .interval (ch_interval[g*CNT_W +: CNT_W]),
         .status   (ch_status[g])
      );
      assign start_vec[g] = ch_status[g].start;
      assign pulse_out[g] = ch_status[g].level;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         event_q <= 1'b0;
      end else begin
         event_q <= |start_vec;
      end
   end

   assign event_flag = event_q;

endmodule

// File: rtl/pig_checker.sv
module pig_checker #(
   parameter int unsigned NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic [NUM_CH-1:0] ch_enable,
   input logic [NUM_CH-1:0] pulse_out,
   input logic              event_flag
);

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (pulse_out == '0 && !event_flag);
      end
   end

   assert_event_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      event_flag |-> $past(tick_en));

   assert_stall_no_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> !event_flag);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_enable[g] |=> !pulse_out[g]);

      assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick_en && ch_enable[g]) |=> $stable(pulse_out[g]));

      assert_rise_flags_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pulse_out[g]) |-> event_flag);

      assert_fall_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(pulse_out[g]) && $past(ch_enable[g])) |-> $past(tick_en));
   end

endmodule

bind pulse_interval_gen pig_checker #(.NUM_CH(NUM_CH)) u_pig_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .ch_enable  (ch_enable),
   .pulse_out  (pulse_out),
   .event_flag (event_flag)
);

// File: tb/pulse_interval_gen_bench.sv
`timescale 1ns/1ps
module pulse_interval_gen_bench;

   localparam int unsigned NUM_CH   = 3;
   localparam int unsigned CNT_W    = 32;
   localparam int unsigned PERIOD_W = 8;
   localparam int unsigned PRSC_W   = 16;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    tick_en = 1'b0;
   logic [PERIOD_W-1:0]     tick_period = '0;
   logic [PRSC_W-1:0]       prescale = '0;
   logic [NUM_CH-1:0]       ch_enable = '0;
   logic [NUM_CH*CNT_W-1:0] ch_interval;
   logic [NUM_CH-1:0]       pulse_out;
   logic                    event_flag;

   logic [CNT_W-1:0] ival [NUM_CH];

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) ch_interval[i*CNT_W +: CNT_W] = ival[i];
   end

   pulse_interval_gen #(
      .NUM_CH   (NUM_CH),
      .CNT_W    (CNT_W),
      .PERIOD_W (PERIOD_W),
      .PRSC_W   (PRSC_W)
   ) u_pulse_interval_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .tick_period (tick_period),
      .prescale    (prescale),
      .ch_enable   (ch_enable),
      .ch_interval (ch_interval),
      .pulse_out   (pulse_out),
      .event_flag  (event_flag)
   );

   int nchk = 0;
   int nerr = 0;
   int ticks = 0;
   logic [NUM_CH-1:0] prev = '0;
   int  last_rise [NUM_CH];
   bit  last_valid [NUM_CH];
   int  next_exp [NUM_CH];
   int  width_exp [NUM_CH];
   bit  high_trk [NUM_CH];
   bit  await_first [NUM_CH];
   int  en_tick [NUM_CH];
   int  first_exp [NUM_CH];
   bit  r8_window = 0;
   int  r8_ch = 0;

   function automatic int exp_ticks(int iv, int tp);
      return (iv + tp - 1) / tp + 1;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   // One clock: sample the inputs seen at the edge, observe after it.
   task automatic step();
      logic [NUM_CH-1:0] en_s;
      int iv_s [NUM_CH];
      int tp_s, ps_s;
      bit tk_s, anyrise;
      en_s = ch_enable;
      tk_s = tick_en;
      tp_s = int'(tick_period);
      ps_s = int'(prescale);
      for (int c = 0; c < NUM_CH; c++) iv_s[c] = int'(ival[c]);
      @(posedge clk);
      if (tk_s) ticks++;
      #1;
      anyrise = 0;
      for (int c = 0; c < NUM_CH; c++) begin
         bit rise, fall;
         rise = pulse_out[c] & ~prev[c];
         fall = ~pulse_out[c] & prev[c];
         if (!en_s[c]) begin
            check(pulse_out[c] == 1'b0, "R2 disabled channel low", int'(pulse_out[c]), 0);
            last_valid[c] = 0;
            high_trk[c]   = 0;
            await_first[c] = 0;
         end else begin
            if (!tk_s)
               check(pulse_out[c] == prev[c], "R6 no tick holds pulse", int'(pulse_out[c]), int'(prev[c]));
            if (rise) begin
               anyrise = 1;
               if (await_first[c]) begin
                  check(ticks - en_tick[c] == first_exp[c], "R4 first pulse tick",
                        ticks - en_tick[c], first_exp[c]);
                  await_first[c] = 0;
               end else if (last_valid[c]) begin
                  if (r8_window && c != r8_ch)
                     check(ticks - last_rise[c] == next_exp[c], "R8 neighbour spacing in ticks",
                           ticks - last_rise[c], next_exp[c]);
                  else
                     check((ticks - last_rise[c]) * tp_s == next_exp[c] * tp_s, "R3 spacing in ns",
                           (ticks - last_rise[c]) * tp_s, next_exp[c] * tp_s);
               end
               last_rise[c]  = ticks;
               last_valid[c] = 1;
               next_exp[c]   = exp_ticks(iv_s[c], tp_s);  // R7 value at the reload tick
               width_exp[c]  = (ps_s == 0) ? 1 : ps_s;
               high_trk[c]   = 1;
            end
            if (fall && high_trk[c]) begin
               check(ticks - last_rise[c] == width_exp[c], "R5 pulse width in ticks",
                     ticks - last_rise[c], width_exp[c]);
               high_trk[c] = 0;
            end
         end
      end
      if (anyrise || event_flag)
         check(event_flag == anyrise, "R9 event flag", int'(event_flag), int'(anyrise));
      prev = pulse_out;
   endtask

   task automatic run(int n, int tick_pct);
      for (int i = 0; i < n; i++) begin
         step();
         tick_en = (($urandom % 100) < tick_pct);
      end
   endtask

   task automatic enable_ch(int c);
      ch_enable[c]   = 1'b1;
      en_tick[c]     = ticks;
      await_first[c] = 1;
      first_exp[c]   = exp_ticks(int'(ival[c]), int'(tick_period));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0417));
      for (int c = 0; c < NUM_CH; c++) begin
         ival[c] = '0;
         last_valid[c] = 0; high_trk[c] = 0; await_first[c] = 0;
         last_rise[c] = 0; next_exp[c] = 0; width_exp[c] = 0; en_tick[c] = 0; first_exp[c] = 0;
      end
      // R1: reset state
      repeat (3) @(negedge clk);
      check(pulse_out == '0, "R1 pulses low in reset", int'(pulse_out), 0);
      check(event_flag == 1'b0, "R1 event low in reset", int'(event_flag), 0);
      tick_period = 8'd10;
      prescale    = 16'd3;
      ival[0] = 32'd40;   // multiple of tick: 5 ticks, 50 ns
      ival[1] = 32'd25;   // partial tick: 4 ticks
      ival[2] = 32'd10;
      @(posedge clk);
      #1 rst_n = 1'b1;
      run(2, 100);
      tick_en = 1'b1;
      enable_ch(0);
      enable_ch(1);
      run(60, 100);
      // R6: stalled time base
      tick_en = 1'b0;
      run(20, 0);
      tick_en = 1'b1;
      run(20, 100);
      // R7: new interval on channel 0 mid-interval
      ival[0] = 32'd70;
      run(40, 100);
      // R8: toggle channel 1 while channel 0 runs
      r8_window = 1; r8_ch = 1;
      ch_enable[1] = 1'b0;
      run(12, 100);
      enable_ch(1);
      run(30, 100);
      r8_window = 0;
      // R5: prescale zero acts as one
      prescale = '0;
      run(30, 100);
      // Random rounds
      for (int r = 0; r < 6; r++) begin
         int tp;
         ch_enable = '0;
         run(2, 100);
         tp = 1 + int'($urandom % 20);
         tick_period = PERIOD_W'(tp);
         prescale = PRSC_W'(1 + ($urandom % 3));
         for (int c = 0; c < NUM_CH; c++) begin
            int lo;
            lo = 3 * tp;
            ival[c] = CNT_W'(lo + int'($urandom % (201 - lo)));
         end
         run(1, 100);
         for (int c = 0; c < NUM_CH; c++) enable_ch(c);
         for (int s = 0; s < 300; s++) begin
            run(1, 60 + int'($urandom % 41));
            if (($urandom % 50) == 0) begin
               int c, lo;
               c  = int'($urandom % NUM_CH);
               lo = 3 * tp;
               if (!await_first[c]) ival[c] = CNT_W'(lo + int'($urandom % (201 - lo)));
            end
         end
      end
      summary();
      $finish;
   end

endmodule